// File: doc/BRIEF.md
# Narrow Access to SDRAM Burst Translator

This block sits between a processor port that issues single loads and stores of 8, 16 or 32 bits and a 16-bit SDRAM-style data port that only moves fixed eight-beat bursts. For each accepted request it splits the byte address into bank, row and column fields. It then issues one burst command at the column rounded down to the burst boundary. On a store it streams all eight beats, with per-byte masks that let only the requested bytes reach the array. On a load it takes all eight returned beats and keeps only the wanted ones.

Byte address bit 0 never reaches the SDRAM address, because the data port is two bytes wide. That bit only picks a byte lane. A configuration input picks one of two places for the bank field. In one, the bank sits just above the column, so consecutive pages rotate across banks. In the other, the bank sits above the row, so each bank covers one contiguous eighth of the space. Only one request is in flight at a time. A one-cycle response pulse ends every request, including rejected ones.

Top module: `sbx_burst_xlate`

## Requirements
- R1: `req_ready` is high only while no request is in flight. An accepted request drops `req_ready` on the next cycle. Each accepted request gets exactly one `rsp_valid` pulse, one cycle long.
- R2: With `cfg_bank_hi`=1, the bank is byte-address bits 28:26 and the row is bits 25:11. The column is bits 10:1.
- R3: With `cfg_bank_hi`=0, the column is byte-address bits 10:1 and the bank is bits 13:11. The row is bits 28:14.
- R4: `cfg_bank_hi` is taken only when a request is accepted. Changing it while a burst is in flight does not alter the bank, row or column of that burst.
- R5: `mem_cmd_valid` is a one-cycle pulse. `mem_col` on it is the column with its three low bits cleared, and `mem_cmd_we` copies `req_write`.
- R6: A store sends exactly eight `mem_wvalid` beats on the eight cycles right after the command, in ascending column order.
- R7: `mem_dm` is active high: bit 0 blocks byte [7:0] and bit 1 blocks byte [15:8]. A byte store leaves only lane `req_addr[0]` of beat (column mod 8) unmasked. A halfword store leaves both lanes of that beat unmasked, and a word store does so for that beat and the next. Every other byte is masked.
- R8: Store data: a byte store puts `req_wdata[7:0]` on both lanes, a halfword puts `req_wdata[15:0]` on its beat, and a word puts `req_wdata[15:0]` on the first beat and `req_wdata[31:16]` on the second. Beats that are not covered carry zero.
- R9: A load consumes eight `mem_rvalid` beats, which may have gaps. The response follows the cycle after the eighth beat. A byte is returned zero-extended in bits 7:0, a halfword in bits 15:0, and a word as {second beat, first beat}. A store response returns zero data.
- R10: Size code 3, a halfword or word at an odd byte address, and a word whose first beat is beat 7 are all rejected. Such a request gets `rsp_err`=1 with zero data, and no command or beat is issued.
- Size encoding on `req_size`: 0 = byte, 1 = halfword, 2 = word, 3 = reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_hi | input | 1 | 1: bank above row; 0: bank between column and row |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | 29 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Load data, right-aligned |
| mem_cmd_valid | output | 1 | Burst command pulse |
| mem_cmd_we | output | 1 | Burst is a write |
| mem_bank | output | 3 | Bank of the burst |
| mem_row | output | 15 | Row of the burst |
| mem_col | output | 10 | Burst start column |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | 16 | Write beat data |
| mem_dm | output | 2 | Write beat byte masks, active high |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 16 | Read beat data |

## Verification
Some properties are checked on every cycle. These are the single-cycle command and response pulses, the one-request-in-flight rule, and the exact count of eight write or read beats behind each good response. Also checked each cycle are the absence of a command before an error response and the steadiness of bank, row and column across a write burst. Only the bench scenarios can show that the field split matches both bank placements, and that the masks, lane placement and right-aligned load data hold at every size and beat offset. The same goes for the boundary offsets: a word at beat 6, a word at beat 7 (rejected), and the top address.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_WBURST,
      ST_RBURST,
      ST_RESP
   } xl_state_e;

   localparam int LANE_W = 8;
   localparam int LANES  = 2;
   localparam int DQ_W   = LANE_W * LANES;
   localparam int CPU_W  = 32;
endpackage

// File: rtl/sbx_addr_map.sv
module sbx_addr_map #(
   parameter int COL_W  = 10,
   parameter int ROW_W  = 15,
   parameter int BANK_W = 3,
   localparam int HW_W  = COL_W + ROW_W + BANK_W
) (
   input  logic [HW_W-1:0]   hw_addr,
   input  logic              bank_hi,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   // Column always occupies the lowest halfword-address bits.
   always_comb begin
      col = hw_addr[COL_W-1:0];
      if (bank_hi) begin
         row  = hw_addr[COL_W +: ROW_W];
         bank = hw_addr[COL_W+ROW_W +: BANK_W];
      end else begin
         bank = hw_addr[COL_W +: BANK_W];
         row  = hw_addr[COL_W+BANK_W +: ROW_W];
      end
   end
endmodule

// File: rtl/sbx_lane_plan.sv
module sbx_lane_plan
   import sbx_pkg::*;
#(
   parameter int BURST_LEN = 8,
   localparam int OFF_W    = $clog2(BURST_LEN)
) (
   input  acc_size_e          size,
   input  logic [OFF_W-1:0]   offs,
   input  logic               byte_hi,
   input  logic [CPU_W-1:0]   wdata,
   input  logic [OFF_W-1:0]   beat,
   output logic [LANES-1:0]   dm,
   output logic [DQ_W-1:0]    wd,
   output logic               lo_hit,
   output logic               hi_hit
);
   logic [BURST_LEN-1:0][LANES-1:0] dm_a;
   logic [BURST_LEN-1:0][DQ_W-1:0]  wd_a;
   logic [OFF_W-1:0]                offs_nxt;

   assign offs_nxt = offs + 1'b1;

   // One mask/data plan per beat position of the burst.
   for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
      localparam logic [OFF_W-1:0] BI = OFF_W'(b);
      logic             first_l;
      logic             second_l;
      logic [LANES-1:0] dm_l;
      logic [DQ_W-1:0]  wd_l;

      assign first_l  = (offs == BI);
      assign second_l = (offs_nxt == BI) && (offs != '1);

      always_comb begin
         dm_l = '1;
         wd_l = '0;
         case (size)
            SZ_BYTE: if (first_l) begin
               dm_l = byte_hi ? 2'b01 : 2'b10;
               wd_l = {LANES{wdata[LANE_W-1:0]}};
            end
            SZ_HALF: if (first_l) begin
               dm_l = '0;
               wd_l = wdata[DQ_W-1:0];
            end
            SZ_WORD: begin
               if (first_l) begin
                  dm_l = '0;
                  wd_l = wdata[DQ_W-1:0];
               end else if (second_l) begin
                  dm_l = '0;
                  wd_l = wdata[CPU_W-1:DQ_W];
               end
            end
            default: ;
         endcase
      end

      assign dm_a[b] = dm_l;
      assign wd_a[b] = wd_l;
   end

   assign dm     = dm_a[beat];
   assign wd     = wd_a[beat];
   assign lo_hit = (beat == offs);
   assign hi_hit = (size == SZ_WORD) && (beat == offs_nxt);
endmodule

// File: rtl/sbx_rd_gather.sv
module sbx_rd_gather
   import sbx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              beat_vld,
   input  logic [DQ_W-1:0]   beat_data,
   input  logic              lo_hit,
   input  logic              hi_hit,
   input  acc_size_e         size,
   input  logic              byte_hi,
   output logic [CPU_W-1:0]  result
);
   logic [DQ_W-1:0] lo_q;
   logic [DQ_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (beat_vld) begin
         if (lo_hit) lo_q <= beat_data;
         if (hi_hit) hi_q <= beat_data;
      end
   end

   always_comb begin
      case (size)
         SZ_BYTE: result = {{(CPU_W-LANE_W){1'b0}},
                            byte_hi ? lo_q[DQ_W-1:LANE_W] : lo_q[LANE_W-1:0]};
         SZ_HALF: result = {{(CPU_W-DQ_W){1'b0}}, lo_q};
         SZ_WORD: result = {hi_q, lo_q};
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/sbx_burst_xlate.sv
module sbx_burst_xlate
   import sbx_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int ROW_W     = 15,
   parameter int BANK_W    = 3,
   parameter int BURST_LEN = 8,
   localparam int HW_W     = COL_W + ROW_W + BANK_W,
   localparam int ADDR_W   = HW_W + 1,
   localparam int OFF_W    = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bank_hi,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              mem_cmd_valid,
   output logic              mem_cmd_we,
   output logic [BANK_W-1:0] mem_bank,
   output logic [ROW_W-1:0]  mem_row,
   output logic [COL_W-1:0]  mem_col,
   output logic              mem_wvalid,
   output logic [15:0]       mem_wdata,
   output logic [1:0]        mem_dm,
   input  logic              mem_rvalid,
   input  logic [15:0]       mem_rdata
);
   // Elaboration-time parameter checks.
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if (COL_W <= OFF_W) begin : g_bad_col
      $error("COL_W must exceed the burst offset width");
   end

   localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BURST_LEN - 1);

   xl_state_e         state_q;
   logic              we_q;
   acc_size_e         size_q;
   logic              byte_hi_q;
   logic [OFF_W-1:0]  offs_q;
   logic [CPU_W-1:0]  wdata_q;
   logic              err_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [OFF_W-1:0]  beat_q;

   logic [BANK_W-1:0] map_bank;
   logic [ROW_W-1:0]  map_row;
   logic [COL_W-1:0]  map_col;
   acc_size_e         size_in;
   logic              bad_req;
   logic              accept;
   logic              plan_lo_hit;
   logic              plan_hi_hit;
   logic [CPU_W-1:0]  gather_res;

   assign size_in = acc_size_e'(req_size);
   assign accept  = req_valid && (state_q == ST_IDLE);

   sbx_addr_map #(
      .COL_W  (COL_W),
      .ROW_W  (ROW_W),
      .BANK_W (BANK_W)
   ) u_map (
      .hw_addr (req_addr[ADDR_W-1:1]),
      .bank_hi (cfg_bank_hi),
      .bank    (map_bank),
      .row     (map_row),
      .col     (map_col)
   );

   // Request legality: odd-aligned wide accesses, reserved size and
   // words whose second halfword would leave the burst are refused.
   always_comb begin
      case (size_in)
         SZ_BYTE: bad_req = 1'b0;
         SZ_HALF: bad_req = req_addr[0];
         SZ_WORD: bad_req = req_addr[0] || (map_col[OFF_W-1:0] == LAST_BEAT);
         default: bad_req = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         we_q      <= 1'b0;
         size_q    <= SZ_BYTE;
         byte_hi_q <= 1'b0;
         offs_q    <= '0;
         wdata_q   <= '0;
         err_q     <= 1'b0;
         bank_q    <= '0;
         row_q     <= '0;
         col_q     <= '0;
         beat_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               we_q      <= req_write;
               size_q    <= size_in;
               byte_hi_q <= req_addr[0];
               offs_q    <= map_col[OFF_W-1:0];
               wdata_q   <= req_wdata;
               err_q     <= bad_req;
               bank_q    <= map_bank;
               row_q     <= map_row;
               col_q     <= {map_col[COL_W-1:OFF_W], {OFF_W{1'b0}}};
               beat_q    <= '0;
               state_q   <= bad_req ? ST_RESP : ST_CMD;
            end
            ST_CMD: begin
               beat_q  <= '0;
               state_q <= we_q ? ST_WBURST : ST_RBURST;
            end
            ST_WBURST: begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) state_q <= ST_RESP;
            end
            ST_RBURST: if (mem_rvalid) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sbx_lane_plan #(
      .BURST_LEN (BURST_LEN)
   ) u_plan (
      .size    (size_q),
      .offs    (offs_q),
      .byte_hi (byte_hi_q),
      .wdata   (wdata_q),
      .beat    (beat_q),
      .dm      (mem_dm),
      .wd      (mem_wdata),
      .lo_hit  (plan_lo_hit),
      .hi_hit  (plan_hi_hit)
   );

   sbx_rd_gather u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .beat_vld  (mem_rvalid && (state_q == ST_RBURST)),
      .beat_data (mem_rdata),
      .lo_hit    (plan_lo_hit),
      .hi_hit    (plan_hi_hit),
      .size      (size_q),
      .byte_hi   (byte_hi_q),
      .result    (gather_res)
   );

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_cmd_valid = (state_q == ST_CMD);
   assign mem_cmd_we    = we_q;
   assign mem_bank      = bank_q;
   assign mem_row       = row_q;
   assign mem_col       = col_q;
   assign mem_wvalid    = (state_q == ST_WBURST);
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_err       = err_q;
   assign rsp_rdata     = (err_q || we_q) ? '0 : gather_res;
endmodule

// File: rtl/sbx_xlate_chk.sv
module sbx_xlate_chk #(
   parameter int COL_W     = 10,
   parameter int ROW_W     = 15,
   parameter int BANK_W    = 3,
   parameter int BURST_LEN = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic              mem_cmd_valid,
   input logic              mem_cmd_we,
   input logic [BANK_W-1:0] mem_bank,
   input logic [ROW_W-1:0]  mem_row,
   input logic [COL_W-1:0]  mem_col,
   input logic              mem_wvalid,
   input logic              mem_rvalid
);
   int   wbeats;
   int   rbeats;
   logic cmd_seen;
   logic we_lat;
   logic rd_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wbeats   <= 0;
         rbeats   <= 0;
         cmd_seen <= 1'b0;
         we_lat   <= 1'b0;
         rd_act   <= 1'b0;
      end else begin
         if (req_valid && req_ready) cmd_seen <= 1'b0;
         if (mem_cmd_valid) begin
            cmd_seen <= 1'b1;
            we_lat   <= mem_cmd_we;
            rd_act   <= !mem_cmd_we;
            wbeats   <= 0;
            rbeats   <= 0;
         end else begin
            if (mem_wvalid) wbeats <= wbeats + 1;
            if (mem_rvalid && rd_act) rbeats <= rbeats + 1;
         end
         if (rsp_valid) rd_act <= 1'b0;
      end
   end

   // R1
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R1
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R5
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid |=> !mem_cmd_valid);
   // R6
   wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err && we_lat) |-> (wbeats == BURST_LEN));
   // R6
   wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wvalid |-> (cmd_seen && we_lat));
   // R9
   rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err && !we_lat) |-> (rbeats == BURST_LEN));
   // R10
   err_nocmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> !cmd_seen);
   // R4
   fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wvalid |-> ($stable(mem_bank) && $stable(mem_row) && $stable(mem_col)));
endmodule

bind sbx_burst_xlate sbx_xlate_chk #(
   .COL_W     (COL_W),
   .ROW_W     (ROW_W),
   .BANK_W    (BANK_W),
   .BURST_LEN (BURST_LEN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_err       (rsp_err),
   .mem_cmd_valid (mem_cmd_valid),
   .mem_cmd_we    (mem_cmd_we),
   .mem_bank      (mem_bank),
   .mem_row       (mem_row),
   .mem_col       (mem_col),
   .mem_wvalid    (mem_wvalid),
   .mem_rvalid    (mem_rvalid)
);

// File: tb/tb_sbx_burst_xlate.sv
`timescale 1ns/1ps
module tb_sbx_burst_xlate;
   typedef struct {
      bit              err;
      bit              we;
      bit [2:0]        bank;
      bit [14:0]       row;
      bit [9:0]        col;
      bit [7:0][1:0]   dm;
      bit [7:0][15:0]  wd;
      bit [31:0]       rdata;
      string           tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bank_hi = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [28:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        mem_cmd_valid, mem_cmd_we;
   logic [2:0]  mem_bank;
   logic [14:0] mem_row;
   logic [9:0]  mem_col;
   logic        mem_wvalid;
   logic [15:0] mem_wdata;
   logic [1:0]  mem_dm;
   logic        mem_rvalid = 1'b0;
   logic [15:0] mem_rdata = '0;

   int   n_vec = 0;
   int   n_fail = 0;
   int   wbeat = 0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   sbx_burst_xlate dut (
      .clk(clk), .rst_n(rst_n), .cfg_bank_hi(cfg_bank_hi),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_we(mem_cmd_we),
      .mem_bank(mem_bank), .mem_row(mem_row), .mem_col(mem_col),
      .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_dm(mem_dm),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit [15:0] pat(bit [2:0] b, bit [14:0] r, bit [9:0] c);
      return {b, 3'b000, c} ^ {r, 1'b0};
   endfunction

   function automatic exp_t model(bit we, bit [1:0] sz, bit [28:0] a,
                                  bit [31:0] wd, bit mode, string tag);
      exp_t e;
      bit [27:0] h = a[28:1];
      bit [2:0]  off = h[2:0];
      bit [2:0]  nx = 3'(off + 3'd1);
      bit [15:0] lo, hi;
      e.tag = tag;
      e.we  = we;
      e.col = {h[9:3], 3'b000};
      if (mode) begin e.bank = h[27:25]; e.row = h[24:10]; end
      else      begin e.bank = h[12:10]; e.row = h[27:13]; end
      e.err = (sz == 2'd3) || (sz != 2'd0 && a[0]) || (sz == 2'd2 && off == 3'd7);
      for (int i = 0; i < 8; i++) begin e.dm[i] = 2'b11; e.wd[i] = '0; end
      case (sz)
         2'd0: begin e.dm[off] = a[0] ? 2'b01 : 2'b10; e.wd[off] = {2{wd[7:0]}}; end
         2'd1: begin e.dm[off] = 2'b00; e.wd[off] = wd[15:0]; end
         2'd2: begin
            e.dm[off] = 2'b00; e.wd[off] = wd[15:0];
            if (off != 3'd7) begin e.dm[nx] = 2'b00; e.wd[nx] = wd[31:16]; end
         end
         default: ;
      endcase
      e.rdata = '0;
      if (!we && !e.err) begin
         lo = pat(e.bank, e.row, e.col + 10'(off));
         hi = pat(e.bank, e.row, e.col + 10'(nx));
         case (sz)
            2'd0: e.rdata = {24'h0, a[0] ? lo[15:8] : lo[7:0]};
            2'd1: e.rdata = {16'h0, lo};
            default: e.rdata = {hi, lo};
         endcase
      end
      return e;
   endfunction

   // Driver: pushes the expected item, offers the request, waits for completion.
   task automatic access(input bit we, input bit [1:0] sz, input bit [28:0] a,
                         input bit [31:0] wd, input bit mode, input bit flip,
                         input string tag);
      exp_q.push_back(model(we, sz, a, wd, mode, tag));
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cfg_bank_hi = mode;
      req_valid = 1'b1; req_write = we; req_size = sz;
      req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      if (flip) cfg_bank_hi = ~mode;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // Memory model: answers read bursts with a gap after the fourth beat.
   initial begin
      bit [2:0]  b;
      bit [14:0] r;
      bit [9:0]  c;
      forever begin
         @(negedge clk);
         if (mem_cmd_valid && !mem_cmd_we) begin
            b = mem_bank; r = mem_row; c = mem_col;
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               if (i == 4) begin mem_rvalid = 1'b0; @(negedge clk); end
               mem_rvalid = 1'b1;
               mem_rdata = pat(b, r, c + 10'(i));
               @(negedge clk);
            end
            mem_rvalid = 1'b0;
         end
      end
   end

   // Monitor: compares command, write beats and response against the queue head.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (mem_cmd_valid || mem_wvalid || rsp_valid) && exp_q.size() == 0)
            check(1'b0, "R1", "activity with nothing outstanding", 32'h1, 32'h0);
         else if (rst_n && exp_q.size() != 0) begin
            if (mem_cmd_valid) begin
               check(!exp_q[0].err, "R10", {exp_q[0].tag, " command on rejected request"}, 32'h1, 32'h0);
               check(mem_cmd_we == exp_q[0].we, "R5", {exp_q[0].tag, " we"}, 32'(mem_cmd_we), 32'(exp_q[0].we));
               check(mem_bank == exp_q[0].bank, exp_q[0].tag, "bank", 32'(mem_bank), 32'(exp_q[0].bank));
               check(mem_row == exp_q[0].row, exp_q[0].tag, "row", 32'(mem_row), 32'(exp_q[0].row));
               check(mem_col == exp_q[0].col, "R5", {exp_q[0].tag, " burst column"}, 32'(mem_col), 32'(exp_q[0].col));
               wbeat = 0;
            end
            if (mem_wvalid) begin
               if (wbeat < 8) begin
                  check(mem_dm == exp_q[0].dm[wbeat], "R7", {exp_q[0].tag, " mask"},
                        32'(mem_dm), 32'(exp_q[0].dm[wbeat]));
                  check(mem_wdata == exp_q[0].wd[wbeat], "R8", {exp_q[0].tag, " beat data"},
                        32'(mem_wdata), 32'(exp_q[0].wd[wbeat]));
               end
               wbeat++;
            end
            if (rsp_valid) begin
               check(rsp_err == exp_q[0].err, "R10", {exp_q[0].tag, " err"}, 32'(rsp_err), 32'(exp_q[0].err));
               check(rsp_rdata == exp_q[0].rdata, "R9", {exp_q[0].tag, " rdata"}, rsp_rdata, exp_q[0].rdata);
               if (exp_q[0].we && !exp_q[0].err)
                  check(wbeat == 8, "R6", {exp_q[0].tag, " write beats"}, 32'(wbeat), 32'd8);
               void'(exp_q.pop_front());
               wbeat = 0;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
      check(!mem_cmd_valid && !mem_wvalid && !rsp_valid, "R1", "idle outputs after reset",
            {29'h0, mem_cmd_valid, mem_wvalid, rsp_valid}, 32'h0);

      // Stores
      access(1'b1, 2'd0, 29'h1234_5679, 32'h0000_00A5, 1'b1, 1'b0, "R2 R7 byte hi-lane");
      access(1'b1, 2'd0, 29'h0765_4324, 32'h0000_003C, 1'b0, 1'b0, "R3 R8 byte lo-lane");
      access(1'b1, 2'd1, 29'h0ABC_DEF6, 32'h0000_BEEF, 1'b0, 1'b0, "R8 half");
      access(1'b1, 2'd2, 29'h1FFF_FFFC, 32'hCAFE_F00D, 1'b1, 1'b0, "R2 word beat6 top");
      access(1'b1, 2'd2, 29'h0000_0000, 32'h1357_9BDF, 1'b0, 1'b0, "R6 word beat0");
      access(1'b1, 2'd2, 29'h0F0F_0F08, 32'h2468_ACE0, 1'b1, 1'b1, "R4 word mode flip");
      // Rejections
      access(1'b1, 2'd2, 29'h0000_001E, 32'hFFFF_FFFF, 1'b0, 1'b0, "R10 word beat7");
      access(1'b1, 2'd1, 29'h0000_0103, 32'h0000_1111, 1'b1, 1'b0, "R10 odd half");
      access(1'b0, 2'd3, 29'h0000_0200, 32'h0, 1'b0, 1'b0, "R10 size3");
      access(1'b0, 2'd2, 29'h1000_000E, 32'h0, 1'b1, 1'b0, "R10 read word beat7");
      // Loads
      access(1'b0, 2'd0, 29'h0ACE_1234, 32'h0, 1'b1, 1'b0, "R9 byte lo");
      access(1'b0, 2'd0, 29'h1BDF_5671, 32'h0, 1'b0, 1'b0, "R9 byte hi");
      access(1'b0, 2'd1, 29'h0321_0ABA, 32'h0, 1'b0, 1'b0, "R3 R9 half");
      access(1'b0, 2'd2, 29'h1765_4326, 32'h0, 1'b1, 1'b0, "R2 R9 word beat3");
      access(1'b0, 2'd1, 29'h1555_AAAC, 32'h0, 1'b0, 1'b1, "R4 half mode flip");
      access(1'b0, 2'd2, 29'h0246_8ACC, 32'h0, 1'b0, 1'b0, "R9 word beat6");

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule